// File: doc/BRIEF.md
# Rewindable FIFO with Level Flags

This block is a single-clock first-in/first-out buffer, nine bits wide by default, with a power-of-two depth. Writes and reads are requested through active-low strobes that are sampled on each rising clock edge. Entries leave in the order they arrived. A write is refused while the buffer is full, and a read is refused while it is empty.

An active-low rewind input moves the read position back to the first storage location. The write position does not move. All data written since the last reset can then be read out again, which suits a sender that has to repeat a packet after an error.

Four active-low level flags report the fill state: full, empty, more-than-half, and a two-sided edge flag for nearly empty or nearly full. Read data is registered. An output-enable input controls a drive qualifier that sits beside the data bus, and it never stops a read from being taken.

Top module: `fifo_rewind9`

## Requirements
- R1: When `rst_n` is sampled low while `wr_n` and `rd_n` are both high, the buffer becomes empty and both positions return to location 0. After that edge `empty_n`=0, `full_n`=1, `half_n`=1, `edge_n`=0 and `dout_en`=0.
- R2: A write is accepted on an edge where `wr_n`=0 and the buffer is not full. When the buffer is full, a write strobe changes neither the occupancy nor the stored data.
- R3: A read is accepted on an edge where `rd_n`=0 and the buffer is not empty. Entries come out in write order. The entry is registered, so it is presented in the cycle after the accepting edge. A read strobe while empty has no effect.
- R4: When a write and a read are both accepted on one edge, the occupancy is unchanged and both positions advance.
- R5: When `rt_n` is sampled low with `rst_n`, `wr_n` and `rd_n` high, reading restarts at location 0. The occupancy becomes the smaller of the number of writes accepted since reset and DEPTH. The write position is unchanged.
- R6: A low `rst_n` or `rt_n` is ignored on any edge where `wr_n` or `rd_n` is low. Any write or read strobed on that edge proceeds normally.
- R7: `full_n` is 0 exactly when the occupancy equals DEPTH. `empty_n` is 0 exactly when the occupancy is 0.
- R8: `half_n` is 0 exactly when the occupancy exceeds DEPTH/2.
- R9: `edge_n` is 0 exactly when the occupancy is at most DEPTH/8 or at least DEPTH-DEPTH/8. Otherwise it is 1.
- R10: `dout_en` is 1 only in the cycle after an accepted read, and only while `oe_n` is 0. `dout` carries the read entry when `dout_en` is 1 and all zeros otherwise. A read taken while `oe_n` is 1 still consumes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, honoured only when both strobes are high |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind of the read position |
| oe_n | input | 1 | Active-low output enable |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, zero when not driven |
| dout_en | output | 1 | Drive qualifier for `dout` |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| half_n | output | 1 | Low when more than half full |
| edge_n | output | 1 | Low when nearly empty or nearly full |

## Verification
The assertions check the following on every cycle:
- full and empty are never asserted together;
- a refused write or read leaves the flags where they were;
- a qualified reset produces the cleared flag set;
- a rewind returns the read position to zero;
- the drive qualifier appears only after an accepted read and only while output enable is low.

Three behaviours need the bench's scenarios: the exact order of the data, the occupancy restored by a rewind, and the flag thresholds at every fill level. The bench sweeps a 16-entry instance through every level, up and down. It then runs mixed traffic against an arithmetic model.

// File: rtl/fifo_rewind9.sv
module fifo_rewind9 #(
  parameter int WIDTH = 9,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             full_n,
  output logic             empty_n,
  output logic             half_n,
  output logic             edge_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CAP    = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HALF   = CAP >> 1;
  localparam logic [AW:0] EIGHTH = CAP >> 3;
  localparam logic [AW:0] UPPER  = CAP - EIGHTH;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt, hw;
  logic [WIDTH-1:0] rdata;
  logic             rvld;

  wire idle   = wr_n & rd_n;
  wire do_rst = ~rst_n & idle;
  wire do_rt  = ~rt_n & rst_n & idle;
  wire wr_ok  = ~wr_n & (cnt != CAP);
  wire rd_ok  = ~rd_n & (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_rst) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      hw   <= '0;
      rvld <= 1'b0;
    end else begin
      rvld <= rd_ok;
      if (wr_ok) wp <= wp + 1'b1;
      if (wr_ok && hw != CAP) hw <= hw + 1'b1;
      if (do_rt) begin
        rp  <= '0;
        cnt <= hw;
      end else begin
        if (rd_ok) rp <= rp + 1'b1;
        case ({wr_ok, rd_ok})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
    if (rd_ok) rdata <= mem[rp];
  end

  assign full_n  = cnt != CAP;
  assign empty_n = cnt != '0;
  assign half_n  = !(cnt > HALF);
  assign edge_n  = (cnt > EIGHTH) && (cnt < UPPER);
  assign dout_en = rvld & ~oe_n;
  assign dout    = dout_en ? rdata : '0;
endmodule

// File: rtl/fifo_rewind9_chk.sv
module fifo_rewind9_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic          oe_n,
  input logic          dout_en,
  input logic          full_n,
  input logic          empty_n,
  input logic          half_n,
  input logic          edge_n,
  input logic [AW-1:0] rp
);
  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (!rst_n && wr_n && rd_n) armed <= 1'b1;

  assert_reset_state_R1: assert property (@(posedge clk)
    (!rst_n && wr_n && rd_n) |=> (!empty_n && full_n && half_n && !edge_n && !dout_en));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!armed)
    (!full_n && !wr_n && rd_n) |=> !full_n);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!armed)
    (!empty_n && !rd_n && wr_n) |=> (!empty_n && !dout_en));

  assert_drive_after_read_R3: assert property (@(posedge clk) disable iff (!armed)
    dout_en |-> $past(!rd_n && empty_n));

  assert_rewind_zero_R5: assert property (@(posedge clk) disable iff (!armed)
    (!rt_n && rst_n && wr_n && rd_n) |=> (rp == '0));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!armed)
    !(!full_n && !empty_n));

  assert_half_nonempty_R8: assert property (@(posedge clk) disable iff (!armed)
    !half_n |-> empty_n);

  assert_edge_extremes_R9: assert property (@(posedge clk) disable iff (!armed)
    (!full_n || !empty_n) |-> !edge_n);

  assert_drive_needs_oe_R10: assert property (@(posedge clk) disable iff (!armed)
    dout_en |-> !oe_n);
endmodule

bind fifo_rewind9 fifo_rewind9_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .oe_n(oe_n),
  .dout_en(dout_en), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
  .edge_n(edge_n), .rp(rp)
);

// File: tb/tb_fifo_rewind9.sv
module tb_fifo_rewind9;
  localparam int W = 9;
  localparam int A = 4;
  localparam int D = 1 << A;

  logic clk = 1'b0;
  logic rst_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, oe_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_en, full_n, empty_n, half_n, edge_n;

  always #4 clk = ~clk;

  fifo_rewind9 #(.WIDTH(W), .AW(A)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en), .full_n(full_n), .empty_n(empty_n),
    .half_n(half_n), .edge_n(edge_n)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] ref_mem [D];
  int m_wp = 0, m_rp = 0, m_cnt = 0, m_hw = 0;
  logic [W-1:0] exp_d = '0;
  bit exp_vld = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input bit rt, input bit rs, input bit oe,
                     input logic [W-1:0] d, input string tag);
    @(negedge clk);
    wr_n = !w; rd_n = !r; rt_n = !rt; rst_n = !rs; oe_n = !oe; din = d;
    if (rs && !w && !r) begin
      m_wp = 0; m_rp = 0; m_cnt = 0; m_hw = 0; exp_vld = 0;
    end else if (rt && !w && !r) begin
      m_rp = 0; m_cnt = m_hw; exp_vld = 0;
    end else begin
      bit wa, ra;
      wa = w && (m_cnt < D);
      ra = r && (m_cnt > 0);
      exp_vld = ra;
      if (ra) begin exp_d = ref_mem[m_rp]; m_rp = (m_rp + 1) % D; end
      if (wa) begin
        ref_mem[m_wp] = d; m_wp = (m_wp + 1) % D;
        if (m_hw < D) m_hw++;
      end
      m_cnt = m_cnt + int'(wa) - int'(ra);
    end
    @(posedge clk);
    #1;
    chk({tag, "/R7 full"}, int'(full_n), int'(m_cnt != D));
    chk({tag, "/R7 empty"}, int'(empty_n), int'(m_cnt != 0));
    chk({tag, "/R8 half"}, int'(half_n), int'(!(m_cnt > D / 2)));
    chk({tag, "/R9 edge"}, int'(edge_n), int'((m_cnt > D / 8) && (m_cnt < D - D / 8)));
    chk({tag, "/R10 en"}, int'(dout_en), int'(exp_vld && oe));
    chk({tag, "/R10 data"}, int'(dout), (exp_vld && oe) ? int'(exp_d) : 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    cyc(0, 0, 0, 1, 0, '0, "R1 reset");
    for (int k = 0; k < D; k++) cyc(1, 0, 0, 0, 1, W'(k * 7 + 3), "R2 fill");
    cyc(1, 0, 0, 0, 1, 9'h1FF, "R2 write when full");
    cyc(1, 0, 0, 0, 1, 9'h155, "R2 write when full");
    for (int k = 0; k < D; k++) cyc(0, 1, 0, 0, k % 2 == 0, '0, "R3 drain R10");
    cyc(0, 1, 0, 0, 1, '0, "R3 read when empty");
    cyc(0, 1, 0, 0, 1, '0, "R3 read when empty");
    cyc(0, 0, 0, 0, 1, '0, "R3 idle after empty read");
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 1, W'(100 + k), "R4 prefill");
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, 0, 1, W'(200 + k), "R4 simultaneous");
    for (int k = 0; k < 5; k++) cyc(0, 1, 0, 0, 1, '0, "R4 drain");
    cyc(0, 0, 0, 1, 0, '0, "R1 reset again");
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, 1, W'(300 + k), "R5 load");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 1, '0, "R5 partial read");
    cyc(0, 0, 1, 0, 1, '0, "R5 rewind");
    for (int k = 0; k < 5; k++) cyc(0, 1, 0, 0, 1, '0, "R5 replay");
    cyc(1, 0, 0, 0, 1, W'(400), "R5 write after rewind");
    cyc(0, 1, 0, 0, 1, '0, "R5 read after rewind");
    cyc(1, 0, 0, 0, 1, W'(401), "R6 load");
    cyc(0, 1, 1, 0, 1, '0, "R6 rewind with read strobe");
    cyc(1, 0, 0, 1, 1, W'(402), "R6 reset with write strobe");
    cyc(0, 1, 0, 0, 1, '0, "R6 read after ignored reset");
    cyc(0, 0, 0, 1, 0, '0, "R1 reset before fill rewind");
    for (int k = 0; k < D + 3; k++) cyc(1, k >= D, 0, 0, 1, W'(500 + k), "R5 wrap load");
    cyc(0, 0, 1, 0, 1, '0, "R5 rewind saturated");
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 1, '0, "R5 replay saturated");
    for (int k = 0; k < 3000; k++) begin
      int sel;
      sel = int'($urandom % 40);
      if (sel == 0) cyc(0, 0, 1, 0, $urandom % 2, '0, "R5 random rewind");
      else if (sel == 1) cyc(0, 0, 0, 1, $urandom % 2, '0, "R1 random reset");
      else cyc($urandom % 2, $urandom % 2, $urandom % 8 == 0, $urandom % 16 == 0,
               $urandom % 2, W'($urandom), "R4 random R6");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule